// File: doc/BRIEF.md
# Down-counting compare timer with register access

This block is a down-counter with a compare register. Software reaches it through a small register bus with single-cycle access. A 12-bit prescaler divides an external tick input, and each prescaled step lowers the counter by one. When the counter reaches zero it either reloads from the load register or wraps to all ones.

Each step that lands the counter on the compare value sets a sticky match flag. Software clears the flag by writing one to it. The flag, masked by an enable bit, drives the interrupt line. The same event also drives an output pin according to a selectable action.

A small run-state machine governs the counter. It has three states:
- `ST_STOP`: the counter holds its value.
- `ST_PRIME`: the counter is loaded once from the load register.
- `ST_COUNT`: the counter steps down on prescaled ticks.

The transitions are:
- `STOP->PRIME`: the enable bit is set while start-from-load is selected.
- `STOP->COUNT`: the enable bit is set without start-from-load.
- `PRIME->COUNT`: the enable bit is still set after the load.
- `PRIME->STOP` and `COUNT->STOP`: the enable bit is cleared, or a soft reset is written.

Top module: `dtm_timer`

## Requirements
- R1: After reset, the register reads are: control 0, status 0, load all ones (CNT_W bits), compare 0 and counter all ones. After reset, `irq` and `cmp_pin` are 0.
- R2: The register offsets are control 0x00, status 0x04, load 0x08, compare 0x0C and counter 0x10. Control reads back bits 15:0 and 25:17 as written; bit 16 and bits 31:26 read 0. Load and compare keep the low CNT_W bits and read back zero-extended. Writes to the counter offset are ignored.
- R3: The control fields used here are: bit 0 enable, bit 1 start-from-load, bits 25:24 clock source, bits 15:4 prescale. Setting enable with start-from-load at 1 loads the counter from the load register within two cycles. Setting enable with start-from-load at 0 resumes from the held count.
- R4: While enabled, the counter decreases by one for every (prescale+1) cycles in which `tick_in` is high.
- R5: With clock source 0, the counter does not change even when enabled.
- R6: A step taken at zero gives the load value when control bit 3 (reload) is 1, and all ones when it is 0. With a load value of all ones and reload set, the full range is counted.
- R7: Status bit 0 is set by the step that makes the counter equal to the compare value. It then stays set.
- R8: Writing status with bit 0 at 1 clears the flag. Writing bit 0 at 0 leaves the flag unchanged.
- R9: `irq` is high exactly when the flag is set and control bit 2 is 1.
- R10: Control bits 23:22 select the pin action on a match: 1 toggle, 2 drive low, 3 drive high. Under 0 the pin reads 0, and matches leave the held level untouched; that level shows again once another action is chosen.
- R11: A load write while control bit 17 is 1 copies the value into the counter at once. While bit 17 is 0, a load write leaves the counter unchanged.
- R12: While enable is 0, the counter holds its value and no match sets the flag.
- R13: Writing control with bit 16 at 1 clears control, status and the pin, and sets the counter to all ones, in one cycle. Load and compare keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_in | input | 1 | Count tick before the prescaler |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, valid with bus_sel |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Match interrupt |
| cmp_pin | output | 1 | Compare-driven output pin |

## Verification
The bench builds the timer with CNT_W set to 16, so the counter is sixteen bits wide. At that width a full-range reload cycle takes 65536 ticks, which is short enough to count through completely. The wrap from zero to all ones and the reload at zero are therefore seen at their real boundary values. The prescale and pin-action cases use small load and compare values, so that several matches occur within a few ticks.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
    localparam int unsigned BUS_W = 32;
    localparam int unsigned ADR_W = 5;
    localparam int unsigned PRE_W = 12;

    localparam logic [ADR_W-1:0] A_CTRL = 5'h00;
    localparam logic [ADR_W-1:0] A_STAT = 5'h04;
    localparam logic [ADR_W-1:0] A_LOAD = 5'h08;
    localparam logic [ADR_W-1:0] A_CMP  = 5'h0C;
    localparam logic [ADR_W-1:0] A_CNT  = 5'h10;

    localparam int unsigned B_EN     = 0;
    localparam int unsigned B_EMODE  = 1;
    localparam int unsigned B_IE     = 2;
    localparam int unsigned B_RLD    = 3;
    localparam int unsigned B_PRE_LO = 4;
    localparam int unsigned B_SRST   = 16;
    localparam int unsigned B_OVW    = 17;
    localparam int unsigned B_PIN_LO = 22;
    localparam int unsigned B_SRC_LO = 24;

    // bits kept in the control register (16 and 31:26 read zero)
    localparam logic [BUS_W-1:0] CTRL_KEEP = 32'h03FE_FFFF;

    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_PRIME = 2'd1,
        ST_COUNT = 2'd2
    } run_state_t;

    typedef enum logic [1:0] {
        PIN_OFF    = 2'd0,
        PIN_TOGGLE = 2'd1,
        PIN_LOW    = 2'd2,
        PIN_HIGH   = 2'd3
    } pin_mode_t;

    typedef struct packed {
        logic             run;
        logic             emode;
        logic             ie;
        logic             reload;
        logic [PRE_W-1:0] presc;
        logic             ovw;
        pin_mode_t        pin;
        logic [1:0]       src;
    } ctrl_t;
endpackage

// File: rtl/dtm_regs.sv
module dtm_regs
    import dtm_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [ADR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0] cnt,
    input  logic             flag,
    output ctrl_t            ctrl,
    output logic [BUS_W-1:0] ctrl_raw,
    output logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cmp_val,
    output logic             srst,
    output logic             w1c,
    output logic             load_wr,
    output logic [BUS_W-1:0] bus_rdata
);
    logic             wr_any;
    logic [BUS_W-1:0] ctrl_q;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] cmp_q;

    assign wr_any  = bus_sel & bus_wr;
    assign srst    = wr_any && (bus_addr == A_CTRL) && bus_wdata[B_SRST];
    assign w1c     = wr_any && (bus_addr == A_STAT) && bus_wdata[0];
    assign load_wr = wr_any && (bus_addr == A_LOAD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            load_q <= '1;
            cmp_q  <= '0;
        end else begin
            if (srst)
                ctrl_q <= '0;
            else if (wr_any && bus_addr == A_CTRL)
                ctrl_q <= bus_wdata & CTRL_KEEP;
            if (load_wr)
                load_q <= bus_wdata[CNT_W-1:0];
            if (wr_any && bus_addr == A_CMP)
                cmp_q <= bus_wdata[CNT_W-1:0];
        end
    end

    assign ctrl.run    = ctrl_q[B_EN];
    assign ctrl.emode  = ctrl_q[B_EMODE];
    assign ctrl.ie     = ctrl_q[B_IE];
    assign ctrl.reload = ctrl_q[B_RLD];
    assign ctrl.presc  = ctrl_q[B_PRE_LO +: PRE_W];
    assign ctrl.ovw    = ctrl_q[B_OVW];
    assign ctrl.pin    = pin_mode_t'(ctrl_q[B_PIN_LO +: 2]);
    assign ctrl.src    = ctrl_q[B_SRC_LO +: 2];

    assign ctrl_raw = ctrl_q;
    assign load_val = load_q;
    assign cmp_val  = cmp_q;

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_q;
            A_STAT:  bus_rdata = {{(BUS_W-1){1'b0}}, flag};
            A_LOAD:  bus_rdata = BUS_W'(load_q);
            A_CMP:   bus_rdata = BUS_W'(cmp_q);
            A_CNT:   bus_rdata = BUS_W'(cnt);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dtm_prescaler.sv
module dtm_prescaler
    import dtm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             active,
    input  logic             tick_in,
    input  logic [PRE_W-1:0] divide,
    output logic             step
);
    logic [PRE_W-1:0] phase_q;
    logic             at_end;

    // >= so that lowering the divider mid-phase never stalls the count
    assign at_end = (phase_q >= divide);
    assign step   = active & tick_in & at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= '0;
        else if (clr || !active)
            phase_q <= '0;
        else if (tick_in)
            phase_q <= at_end ? '0 : phase_q + 1'b1;
    end
endmodule

// File: rtl/dtm_counter.sv
module dtm_counter
    import dtm_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst,
    input  logic             run,
    input  logic             emode,
    input  logic             reload,
    input  logic             step,
    input  logic             ovw_wr,
    input  logic [CNT_W-1:0] ovw_val,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] cmp_val,
    output run_state_t       state,
    output logic [CNT_W-1:0] cnt,
    output logic             match
);
    run_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] after_step;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP:  if (run) state_d = emode ? ST_PRIME : ST_COUNT;
            ST_PRIME: state_d = run ? ST_COUNT : ST_STOP;
            ST_COUNT: if (!run) state_d = ST_STOP;
            default:  state_d = ST_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_STOP;
        else if (srst)
            state_q <= ST_STOP;
        else
            state_q <= state_d;
    end

    assign after_step = (cnt_q == '0) ? (reload ? load_val : '1) : cnt_q - 1'b1;
    assign match      = step && !srst && !ovw_wr && (after_step == cmp_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '1;
        else if (srst)
            cnt_q <= '1;
        else if (ovw_wr)
            cnt_q <= ovw_val;
        else if (state_q == ST_PRIME)
            cnt_q <= load_val;
        else if (step)
            cnt_q <= after_step;
    end

    assign state = state_q;
    assign cnt   = cnt_q;
endmodule

// File: rtl/dtm_event.sv
module dtm_event
    import dtm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      srst,
    input  logic      match,
    input  logic      w1c,
    input  pin_mode_t mode,
    output logic      flag,
    output logic      pin_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (srst)
            flag <= 1'b0;
        else if (match)
            flag <= 1'b1;
        else if (w1c)
            flag <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pin_q <= 1'b0;
        else if (srst)
            pin_q <= 1'b0;
        else if (match) begin
            unique case (mode)
                PIN_TOGGLE: pin_q <= ~pin_q;
                PIN_LOW:    pin_q <= 1'b0;
                PIN_HIGH:   pin_q <= 1'b1;
                default:    pin_q <= pin_q;
            endcase
        end
    end
endmodule

// File: rtl/dtm_timer.sv
module dtm_timer
    import dtm_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_in,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        cmp_pin
);
    ctrl_t            ctrl;
    logic [BUS_W-1:0] ctrl_raw;
    logic [CNT_W-1:0] load_val, cmp_val, cnt;
    logic             srst, w1c, load_wr, ovw_wr;
    logic             step, match, flag, pin_q;
    run_state_t       state;

    assign ovw_wr = load_wr & ctrl.ovw;

    dtm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .cnt(cnt), .flag(flag),
        .ctrl(ctrl), .ctrl_raw(ctrl_raw), .load_val(load_val), .cmp_val(cmp_val),
        .srst(srst), .w1c(w1c), .load_wr(load_wr), .bus_rdata(bus_rdata)
    );

    dtm_prescaler u_pre (
        .clk(clk), .rst_n(rst_n), .clr(srst),
        .active((state == ST_COUNT) && (ctrl.src != 2'd0)),
        .tick_in(tick_in), .divide(ctrl.presc), .step(step)
    );

    dtm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .srst(srst),
        .run(ctrl.run), .emode(ctrl.emode), .reload(ctrl.reload), .step(step),
        .ovw_wr(ovw_wr), .ovw_val(bus_wdata[CNT_W-1:0]),
        .load_val(load_val), .cmp_val(cmp_val),
        .state(state), .cnt(cnt), .match(match)
    );

    dtm_event u_evt (
        .clk(clk), .rst_n(rst_n), .srst(srst), .match(match), .w1c(w1c),
        .mode(ctrl.pin), .flag(flag), .pin_q(pin_q)
    );

    assign irq     = flag & ctrl.ie;
    assign cmp_pin = (ctrl.pin == PIN_OFF) ? 1'b0 : pin_q;
endmodule

// File: rtl/dtm_checker.sv
module dtm_checker
    import dtm_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input run_state_t       state,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] load_val,
    input logic             step,
    input logic             match,
    input logic             flag,
    input logic             irq,
    input logic             cmp_pin,
    input logic             srst,
    input logic             w1c,
    input logic             ovw_wr,
    input logic [BUS_W-1:0] ctrl_raw
);
    a_r3_prime_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRIME && !srst && !ovw_wr) |=> cnt == $past(load_val));

    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !srst && !ovw_wr && cnt != '0) |=> (cnt + 1'b1) == $past(cnt));

    a_r5_src_off_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_raw[B_SRC_LO +: 2] == 2'd0) |-> !step);

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !w1c && !srst) |=> flag);

    a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c && !match && !srst) |=> !flag);

    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && ctrl_raw[B_IE]));

    a_r10_drive_high: assert property (@(posedge clk) disable iff (!rst_n)
        (match && ctrl_raw[B_PIN_LO +: 2] == 2'd3 && !srst) |=>
            (cmp_pin || ctrl_raw[B_PIN_LO +: 2] == 2'd0));

    a_r12_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && !srst && !ovw_wr) |=> $stable(cnt));

    a_r12_no_match_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_COUNT) |-> !match);

    a_r13_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (ctrl_raw == '0 && !flag && cnt == '1));
endmodule

bind dtm_timer dtm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .cnt(cnt), .load_val(load_val),
    .step(step), .match(match), .flag(flag), .irq(irq), .cmp_pin(cmp_pin),
    .srst(srst), .w1c(w1c), .ovw_wr(ovw_wr), .ctrl_raw(ctrl_raw)
);

// File: tb/sim_dtm_timer.sv
`timescale 1ns/1ps
module sim_dtm_timer;
    localparam int unsigned CW = 16;
    localparam logic [4:0] O_CTRL = 5'h00, O_STAT = 5'h04, O_LOAD = 5'h08,
                           O_CMP = 5'h0C, O_CNT = 5'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_in = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, cmp_pin;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dtm_timer #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .cmp_pin(cmp_pin)
    );

    function automatic logic [31:0] cw(input bit en, input bit em, input bit ie, input bit rld,
                                       input logic [11:0] pre, input bit ovw,
                                       input logic [1:0] pin, input logic [1:0] src);
        return {6'b0, src, pin, 4'b0, ovw, 1'b0, pre, rld, ie, em, en};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        tick_in = 1'b1;
        repeat (n) @(negedge clk);
        tick_in = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl", O_CTRL, 32'h0);
        rd_chk("R1 status", O_STAT, 32'h0);
        rd_chk("R1 load", O_LOAD, 32'h0000FFFF);
        rd_chk("R1 compare", O_CMP, 32'h0);
        rd_chk("R1 counter", O_CNT, 32'h0000FFFF);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 pin", {31'b0, cmp_pin}, 32'h0);
    endtask

    task automatic t_regmap;
        wr(O_CTRL, 32'hFFFE_FFFE);
        rd_chk("R2 ctrl readback", O_CTRL, 32'h03FE_FFFE);
        wr(O_CMP, 32'hABCD_1234);
        rd_chk("R2 compare width", O_CMP, 32'h0000_1234);
        wr(O_CNT, 32'h0);
        rd_chk("R2 counter read-only", O_CNT, 32'h0000FFFF);
        rd_chk("R2 unmapped", 5'h14, 32'h0);
        wr(O_CTRL, 32'h0);
    endtask

    task automatic t_count;
        wr(O_LOAD, 32'd20);
        wr(O_CMP, 32'h7000);
        wr(O_CTRL, cw(1, 1, 0, 0, 12'd0, 0, 2'd0, 2'd1));
        idle(3);
        rd_chk("R3 start loads", O_CNT, 32'd20);
        ticks(5);
        rd_chk("R4 prescale 0", O_CNT, 32'd15);
        wr(O_CTRL, cw(1, 1, 0, 0, 12'd2, 0, 2'd0, 2'd1));
        ticks(6);
        rd_chk("R4 prescale 2", O_CNT, 32'd13);
    endtask

    task automatic t_src_off;
        wr(O_CTRL, cw(1, 1, 0, 0, 12'd0, 0, 2'd0, 2'd0));
        ticks(4);
        rd_chk("R5 source off", O_CNT, 32'd13);
    endtask

    task automatic t_stop_flag_irq;
        wr(O_CMP, 32'd12);
        wr(O_CTRL, cw(0, 1, 0, 0, 12'd0, 0, 2'd0, 2'd1));
        idle(1);
        ticks(5);
        rd_chk("R12 hold", O_CNT, 32'd13);
        rd_chk("R12 no flag", O_STAT, 32'h0);
        wr(O_CTRL, cw(1, 0, 0, 0, 12'd0, 0, 2'd0, 2'd1));
        idle(2);
        rd_chk("R3 resume held", O_CNT, 32'd13);
        ticks(1);
        rd_chk("R7 match sets", O_STAT, 32'h1);
        chk("R9 masked", {31'b0, irq}, 32'h0);
        ticks(3);
        rd_chk("R7 sticky", O_STAT, 32'h1);
        rd_chk("R4 after match", O_CNT, 32'd9);
        wr(O_CTRL, cw(1, 0, 1, 0, 12'd0, 0, 2'd0, 2'd1));
        chk("R9 enabled", {31'b0, irq}, 32'h1);
        wr(O_STAT, 32'h0);
        rd_chk("R8 write zero", O_STAT, 32'h1);
        wr(O_STAT, 32'h1);
        rd_chk("R8 write one", O_STAT, 32'h0);
        chk("R9 cleared", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_soft_reset;
        wr(O_CMP, 32'd8);
        ticks(1);
        rd_chk("R7 second match", O_STAT, 32'h1);
        wr(O_LOAD, 32'h100);
        rd_chk("R11 no overwrite", O_CNT, 32'd8);
        wr(O_CTRL, 32'h0001_0000);
        rd_chk("R13 ctrl", O_CTRL, 32'h0);
        rd_chk("R13 status", O_STAT, 32'h0);
        rd_chk("R13 counter", O_CNT, 32'h0000FFFF);
        rd_chk("R13 load kept", O_LOAD, 32'h100);
        rd_chk("R13 compare kept", O_CMP, 32'd8);
    endtask

    task automatic t_wrap;
        wr(O_LOAD, 32'd3);
        wr(O_CMP, 32'h7000);
        wr(O_CTRL, cw(1, 1, 0, 0, 12'd0, 0, 2'd0, 2'd1));
        idle(3);
        ticks(4);
        rd_chk("R6 wrap to ones", O_CNT, 32'h0000FFFF);
        ticks(1);
        rd_chk("R6 after wrap", O_CNT, 32'h0000FFFE);
        wr(O_CTRL, 32'h0001_0000);
        wr(O_CTRL, cw(1, 1, 0, 1, 12'd0, 0, 2'd0, 2'd1));
        idle(3);
        ticks(4);
        rd_chk("R6 reload", O_CNT, 32'd3);
        wr(O_CTRL, 32'h0001_0000);
        wr(O_LOAD, 32'h0000FFFF);
        wr(O_CTRL, cw(1, 1, 0, 1, 12'd0, 0, 2'd0, 2'd1));
        idle(3);
        rd_chk("R6 full start", O_CNT, 32'h0000FFFF);
        ticks(65536);
        rd_chk("R6 full range", O_CNT, 32'h0000FFFF);
        ticks(1);
        rd_chk("R6 full next", O_CNT, 32'h0000FFFE);
    endtask

    task automatic t_pin;
        wr(O_CTRL, 32'h0001_0000);
        wr(O_LOAD, 32'd3);
        wr(O_CMP, 32'd1);
        wr(O_CTRL, cw(1, 1, 0, 1, 12'd0, 0, 2'd1, 2'd1));
        idle(3);
        chk("R10 pin idle", {31'b0, cmp_pin}, 32'h0);
        ticks(2);
        chk("R10 toggle up", {31'b0, cmp_pin}, 32'h1);
        ticks(4);
        chk("R10 toggle down", {31'b0, cmp_pin}, 32'h0);
        wr(O_CTRL, cw(1, 1, 0, 1, 12'd0, 0, 2'd3, 2'd1));
        ticks(4);
        chk("R10 drive high", {31'b0, cmp_pin}, 32'h1);
        wr(O_CTRL, cw(1, 1, 0, 1, 12'd0, 0, 2'd2, 2'd1));
        ticks(4);
        chk("R10 drive low", {31'b0, cmp_pin}, 32'h0);
        wr(O_CTRL, cw(1, 1, 0, 1, 12'd0, 0, 2'd3, 2'd1));
        ticks(4);
        wr(O_CTRL, cw(1, 1, 0, 1, 12'd0, 0, 2'd0, 2'd1));
        chk("R10 off reads low", {31'b0, cmp_pin}, 32'h0);
        ticks(4);
        wr(O_CTRL, cw(1, 1, 0, 1, 12'd0, 0, 2'd1, 2'd1));
        chk("R10 off keeps level", {31'b0, cmp_pin}, 32'h1);
    endtask

    task automatic t_overwrite;
        wr(O_CTRL, 32'h0001_0000);
        wr(O_CTRL, cw(0, 0, 0, 0, 12'd0, 1, 2'd0, 2'd0));
        wr(O_LOAD, 32'h55);
        rd_chk("R11 overwrite", O_CNT, 32'h55);
        rd_chk("R11 load value", O_LOAD, 32'h55);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset;
        t_regmap;
        t_count;
        t_src_off;
        t_stop_flag_irq;
        t_soft_reset;
        t_wrap;
        t_pin;
        t_overwrite;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule